// File: doc/BRIEF.md
# Timer-Driven Converter Access Sequencer

The sequencer owns the shared bus between a host and a pair of parallel converters used as an audio front end: a 10-bit ADC and an 8-bit DAC. Fixed I/O addresses are decoded into two chip selects, and at most one of them is active at a time. After reset the block loads two setup words into the ADC. Only then does the sample clock start.

A divider with a 16-bit reload value produces one tick every reload+1 clocks, so changing the reload changes the sample rate. Each tick runs one sequence:

- The staged DAC sample is written.
- An ADC conversion is started.
- The block waits a programmable number of cycles.
- It pulses the ADC read control and captures the result.

The result stays in a holding register with a valid flag and an overrun flag until the host reads it. The host stages the next DAC sample by writing the DAC address.

A tick that comes while a sequence is still running starts no extra sequence. The reload should therefore be at least the wait count plus three.

Top module: `conv_access_seq`

## Requirements
- R1: After reset, the converter side is quiet. The first two converter writes go to the ADC select and carry 0x00C0 and then 0x0100, on consecutive cycles. No DAC write, ADC start or ADC read comes before them.
- R2: The DAC select and the ADC select are never high together. Every converter write, start or read strobe comes with exactly one select.
- R3: Once setup is done, DAC writes repeat every reload+1 clock cycles, where reload is the tick reload value. A new reload value takes effect from the tick after the one that follows the change.
- R4: Each tick gives one cycle with the write strobe and DAC select. The data bus carries the staged sample in bits 7:0 and zero above. The next cycle carries the ADC start with the ADC select and no write strobe.
- R5: After the start cycle, exactly wait-count cycles follow with no strobe and no select. Then one cycle has the ADC read control high with the ADC select. A wait count of 0 puts the read in the cycle right after the start.
- R6: The ADC data present during the read cycle is captured. A host read of address 0x0002 returns it in bits 9:0, with bit 15 (valid) set.
- R7: A host read of address 0x0002 clears bit 15 (valid) and bit 14 (overrun) from the next cycle on. The sample bits 9:0 are kept.
- R8: If a new sample is captured while valid is still set, bit 14 (overrun) is set. The new sample replaces the old one.
- R9: A host write to address 0x0001 stages bits 7:0 of the write data as the next DAC sample. A host read of 0x0001 returns the staged sample zero-extended.
- R10: Host reads of any address other than 0x0001 and 0x0002 return zero and leave the flags unchanged. Host writes to any address other than 0x0001 leave the staged sample unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| io_addr_i | input | 16 | Host I/O address |
| io_wr_i | input | 1 | Host write strobe |
| io_rd_i | input | 1 | Host read strobe |
| io_wdata_i | input | 8 | Host write data (DAC sample) |
| io_rdata_o | output | 16 | Host read data, zero when not reading a mapped address |
| tick_reload_i | input | 16 | Tick divider reload; period is reload+1 clocks |
| conv_wait_i | input | 8 | Cycles between ADC start and ADC read |
| conv_dout_o | output | 16 | Data driven onto the converter bus during writes |
| conv_wr_o | output | 1 | Converter write strobe |
| dac_sel_o | output | 1 | DAC chip select |
| adc_sel_o | output | 1 | ADC chip select |
| adc_start_o | output | 1 | ADC conversion start |
| adc_rd_o | output | 1 | ADC read control |
| adc_din_i | input | 10 | ADC result data |

## Verification
The overrun case is the hardest to reach from the ports. The host has to stay silent across two full tick sequences, and its clearing read must not land in a capture cycle. The bench gets there by timing itself from the observed DAC write strobe. It issues a clearing read during the following start cycle, lets two captures pass with different ADC data, and then reads the sample register twice.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef enum logic [2:0] {
    ST_BOOT  = 3'd0,
    ST_CFG0  = 3'd1,
    ST_CFG1  = 3'd2,
    ST_IDLE  = 3'd3,
    ST_DAC   = 3'd4,
    ST_START = 3'd5,
    ST_WAIT  = 3'd6,
    ST_READ  = 3'd7
  } seq_state_e;

endpackage

// File: rtl/conv_addr_decode.sv
module conv_addr_decode #(
  parameter int unsigned            ADDR_W  = 16,
  parameter int unsigned            N_DEV   = 2,
  parameter logic [N_DEV*ADDR_W-1:0] DEV_MAP = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              act_i,
  output logic [N_DEV-1:0]  sel_o
);

  for (genvar g = 0; g < N_DEV; g++) begin : g_dev
    assign sel_o[g] = act_i && (addr_i == DEV_MAP[g*ADDR_W +: ADDR_W]);
  end

endmodule

// File: rtl/conv_tick_gen.sv
module conv_tick_gen #(
  parameter int unsigned TICK_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [TICK_W-1:0] reload_i,
  output logic              tick_o
);

  logic [TICK_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    tick_o = 1'b0;
    if (!en_i) begin
      cnt_d  = reload_i;
      cnt_en = 1'b1;
    end else if (cnt_q == '0) begin
      tick_o = 1'b1;
      cnt_d  = reload_i;
      cnt_en = 1'b1;
    end else begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/conv_seq_fsm.sv
module conv_seq_fsm
  import conv_seq_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       DATA_W    = 16,
  parameter int unsigned       DAC_W     = 8,
  parameter int unsigned       CNT_W     = 8,
  parameter logic [ADDR_W-1:0] DAC_ADDR  = 16'h0001,
  parameter logic [ADDR_W-1:0] ADC_ADDR  = 16'h0002,
  parameter logic [DATA_W-1:0] CFG_WORD0 = 16'h00C0,
  parameter logic [DATA_W-1:0] CFG_WORD1 = 16'h0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  conv_wait_i,
  input  logic [DAC_W-1:0]  dac_stage_i,
  output logic              bus_act_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_wr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              adc_start_o,
  output logic              adc_rd_o,
  output logic              capture_o,
  output logic              init_done_o
);

  localparam int unsigned PAD_W = DATA_W - DAC_W;

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] wait_q, wait_d;
  logic             wait_en;

  // next state
  always_comb begin
    state_d = state_q;
    wait_d  = wait_q;
    wait_en = 1'b0;
    unique case (state_q)
      ST_BOOT:  state_d = ST_CFG0;
      ST_CFG0:  state_d = ST_CFG1;
      ST_CFG1:  state_d = ST_IDLE;
      ST_IDLE:  if (tick_i) state_d = ST_DAC;
      ST_DAC:   state_d = ST_START;
      ST_START: begin
        if (conv_wait_i == '0) begin
          state_d = ST_READ;
        end else begin
          state_d = ST_WAIT;
          wait_d  = conv_wait_i;
          wait_en = 1'b1;
        end
      end
      ST_WAIT: begin
        if (wait_q <= CNT_W'(1)) begin
          state_d = ST_READ;
        end else begin
          wait_d  = wait_q - 1'b1;
          wait_en = 1'b1;
        end
      end
      ST_READ:  state_d = ST_IDLE;
      default:  state_d = ST_BOOT;
    endcase
  end

  // outputs decoded from the state
  always_comb begin
    bus_act_o   = 1'b0;
    bus_addr_o  = '0;
    bus_wr_o    = 1'b0;
    bus_wdata_o = '0;
    adc_start_o = 1'b0;
    adc_rd_o    = 1'b0;
    capture_o   = 1'b0;
    unique case (state_q)
      ST_CFG0: begin
        bus_act_o   = 1'b1;
        bus_addr_o  = ADC_ADDR;
        bus_wr_o    = 1'b1;
        bus_wdata_o = CFG_WORD0;
      end
      ST_CFG1: begin
        bus_act_o   = 1'b1;
        bus_addr_o  = ADC_ADDR;
        bus_wr_o    = 1'b1;
        bus_wdata_o = CFG_WORD1;
      end
      ST_DAC: begin
        bus_act_o   = 1'b1;
        bus_addr_o  = DAC_ADDR;
        bus_wr_o    = 1'b1;
        bus_wdata_o = {{PAD_W{1'b0}}, dac_stage_i};
      end
      ST_START: begin
        bus_act_o   = 1'b1;
        bus_addr_o  = ADC_ADDR;
        adc_start_o = 1'b1;
      end
      ST_READ: begin
        bus_act_o   = 1'b1;
        bus_addr_o  = ADC_ADDR;
        adc_rd_o    = 1'b1;
        capture_o   = 1'b1;
      end
      default: ;
    endcase
  end

  assign init_done_o = !(state_q inside {ST_BOOT, ST_CFG0, ST_CFG1});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_BOOT;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= '0;
    end else if (wait_en) begin
      wait_q <= wait_d;
    end
  end

endmodule

// File: rtl/conv_host_regs.sv
module conv_host_regs #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADC_W  = 10,
  parameter int unsigned DAC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [DAC_W-1:0]  io_wdata_i,
  input  logic              hit_dac_i,
  input  logic              hit_adc_i,
  input  logic              capture_i,
  input  logic [ADC_W-1:0]  cap_data_i,
  output logic [DAC_W-1:0]  stage_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DAC_W-1:0] stage_q;
  logic [ADC_W-1:0] hold_q, hold_d;
  logic             valid_q, valid_d;
  logic             ovr_q, ovr_d;
  logic             stage_en, hold_en, flag_en, rd_clr;
  logic [DATA_W-1:0] adc_word;

  assign stage_en = io_wr_i && hit_dac_i;
  assign rd_clr   = io_rd_i && hit_adc_i;
  assign hold_en  = capture_i;
  assign flag_en  = capture_i || rd_clr;

  always_comb begin
    hold_d  = cap_data_i;
    valid_d = valid_q;
    ovr_d   = ovr_q;
    if (capture_i) begin
      valid_d = 1'b1;
      ovr_d   = (valid_q || ovr_q) && !rd_clr;
    end else if (rd_clr) begin
      valid_d = 1'b0;
      ovr_d   = 1'b0;
    end
  end

  always_comb begin
    adc_word             = '0;
    adc_word[DATA_W-1]   = valid_q;
    adc_word[DATA_W-2]   = ovr_q;
    adc_word[ADC_W-1:0]  = hold_q;
    rdata_o              = '0;
    if (io_rd_i && hit_adc_i) begin
      rdata_o = adc_word;
    end else if (io_rd_i && hit_dac_i) begin
      rdata_o = {{(DATA_W-DAC_W){1'b0}}, stage_q};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else if (stage_en) begin
      stage_q <= io_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (flag_en) begin
      valid_q <= valid_d;
      ovr_q   <= ovr_d;
    end
  end

  assign stage_o = stage_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/conv_access_seq.sv
module conv_access_seq #(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       DATA_W    = 16,
  parameter int unsigned       ADC_W     = 10,
  parameter int unsigned       DAC_W     = 8,
  parameter int unsigned       TICK_W    = 16,
  parameter int unsigned       CNT_W     = 8,
  parameter logic [ADDR_W-1:0] DAC_ADDR  = 16'h0001,
  parameter logic [ADDR_W-1:0] ADC_ADDR  = 16'h0002,
  parameter logic [DATA_W-1:0] CFG_WORD0 = 16'h00C0,
  parameter logic [DATA_W-1:0] CFG_WORD1 = 16'h0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [DAC_W-1:0]  io_wdata_i,
  output logic [DATA_W-1:0] io_rdata_o,
  input  logic [TICK_W-1:0] tick_reload_i,
  input  logic [CNT_W-1:0]  conv_wait_i,
  output logic [DATA_W-1:0] conv_dout_o,
  output logic              conv_wr_o,
  output logic              dac_sel_o,
  output logic              adc_sel_o,
  output logic              adc_start_o,
  output logic              adc_rd_o,
  input  logic [ADC_W-1:0]  adc_din_i
);

  localparam int unsigned             N_DEV   = 2;
  localparam int unsigned             IDX_DAC = 0;
  localparam int unsigned             IDX_ADC = 1;
  localparam logic [N_DEV*ADDR_W-1:0] DEV_MAP = {ADC_ADDR, DAC_ADDR};
  localparam int unsigned             SYNC_N  = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[SYNC_N-1];

  logic              tick;
  logic              init_done;
  logic              bus_act, bus_wr, capture;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DAC_W-1:0]  dac_stage;
  logic              sample_valid;
  logic [N_DEV-1:0]  conv_sel, host_sel;

  conv_tick_gen #(.TICK_W(TICK_W)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .en_i     (init_done),
    .reload_i (tick_reload_i),
    .tick_o   (tick)
  );

  conv_seq_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DAC_W(DAC_W), .CNT_W(CNT_W),
    .DAC_ADDR(DAC_ADDR), .ADC_ADDR(ADC_ADDR),
    .CFG_WORD0(CFG_WORD0), .CFG_WORD1(CFG_WORD1)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .tick_i      (tick),
    .conv_wait_i (conv_wait_i),
    .dac_stage_i (dac_stage),
    .bus_act_o   (bus_act),
    .bus_addr_o  (bus_addr),
    .bus_wr_o    (bus_wr),
    .bus_wdata_o (bus_wdata),
    .adc_start_o (adc_start_o),
    .adc_rd_o    (adc_rd_o),
    .capture_o   (capture),
    .init_done_o (init_done)
  );

  conv_addr_decode #(.ADDR_W(ADDR_W), .N_DEV(N_DEV), .DEV_MAP(DEV_MAP)) u_conv_dec (
    .addr_i (bus_addr),
    .act_i  (bus_act),
    .sel_o  (conv_sel)
  );

  conv_addr_decode #(.ADDR_W(ADDR_W), .N_DEV(N_DEV), .DEV_MAP(DEV_MAP)) u_host_dec (
    .addr_i (io_addr_i),
    .act_i  (io_rd_i || io_wr_i),
    .sel_o  (host_sel)
  );

  conv_host_regs #(.DATA_W(DATA_W), .ADC_W(ADC_W), .DAC_W(DAC_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .io_wr_i    (io_wr_i),
    .io_rd_i    (io_rd_i),
    .io_wdata_i (io_wdata_i),
    .hit_dac_i  (host_sel[IDX_DAC]),
    .hit_adc_i  (host_sel[IDX_ADC]),
    .capture_i  (capture),
    .cap_data_i (adc_din_i),
    .stage_o    (dac_stage),
    .valid_o    (sample_valid),
    .rdata_o    (io_rdata_o)
  );

  assign dac_sel_o   = conv_sel[IDX_DAC];
  assign adc_sel_o   = conv_sel[IDX_ADC];
  assign conv_wr_o   = bus_wr;
  assign conv_dout_o = bus_wr ? bus_wdata : '0;

endmodule

// File: rtl/conv_access_seq_checker.sv
module conv_access_seq_checker #(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       DATA_W    = 16,
  parameter int unsigned       CNT_W     = 8,
  parameter logic [ADDR_W-1:0] ADC_ADDR  = 16'h0002,
  parameter logic [DATA_W-1:0] CFG_WORD0 = 16'h00C0,
  parameter logic [DATA_W-1:0] CFG_WORD1 = 16'h0100
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              io_rd_i,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic [CNT_W-1:0]  conv_wait_i,
  input logic [DATA_W-1:0] conv_dout_o,
  input logic              conv_wr_o,
  input logic              dac_sel_o,
  input logic              adc_sel_o,
  input logic              adc_start_o,
  input logic              adc_rd_o,
  input logic              sample_valid
);

  logic [1:0] cfg_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_cnt_q <= '0;
    end else if (conv_wr_o && adc_sel_o && cfg_cnt_q != 2'd2) begin
      cfg_cnt_q <= cfg_cnt_q + 2'd1;
    end
  end

  assert_one_select_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dac_sel_o && adc_sel_o));

  assert_strobe_select_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_wr_o || adc_start_o || adc_rd_o) |-> (dac_sel_o || adc_sel_o));

  assert_first_word_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_wr_o && cfg_cnt_q == 2'd0) |-> (adc_sel_o && conv_dout_o == CFG_WORD0));

  assert_second_word_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_wr_o && cfg_cnt_q == 2'd1) |-> (adc_sel_o && conv_dout_o == CFG_WORD1));

  assert_setup_first_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_start_o || adc_rd_o || (conv_wr_o && dac_sel_o)) |-> (cfg_cnt_q == 2'd2));

  assert_start_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_wr_o && dac_sel_o) |=> (adc_start_o && adc_sel_o && !conv_wr_o));

  assert_zero_wait_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_start_o && conv_wait_i == '0) |=> (adc_rd_o && adc_sel_o));

  assert_capture_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_rd_o |=> sample_valid);

  assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && io_addr_i == ADC_ADDR && !adc_rd_o) |=> !sample_valid);

endmodule

bind conv_access_seq conv_access_seq_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
  .ADC_ADDR(ADC_ADDR), .CFG_WORD0(CFG_WORD0), .CFG_WORD1(CFG_WORD1)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .io_rd_i      (io_rd_i),
  .io_addr_i    (io_addr_i),
  .conv_wait_i  (conv_wait_i),
  .conv_dout_o  (conv_dout_o),
  .conv_wr_o    (conv_wr_o),
  .dac_sel_o    (dac_sel_o),
  .adc_sel_o    (adc_sel_o),
  .adc_start_o  (adc_start_o),
  .adc_rd_o     (adc_rd_o),
  .sample_valid (sample_valid)
);

// File: tb/conv_access_seq_bench.sv
`timescale 1ns/1ps
module conv_access_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] io_addr;
  logic        io_wr, io_rd;
  logic [7:0]  io_wdata;
  logic [15:0] io_rdata;
  logic [15:0] tick_reload;
  logic [7:0]  conv_wait;
  logic [15:0] conv_dout;
  logic        conv_wr, dac_sel, adc_sel, adc_start, adc_rd;
  logic [9:0]  adc_din;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int sel_clash = 0;
  bit done    = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;
  always @(negedge clk) if (dac_sel && adc_sel) sel_clash++;

  conv_access_seq u_conv_access_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .io_addr_i(io_addr), .io_wr_i(io_wr), .io_rd_i(io_rd),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .tick_reload_i(tick_reload), .conv_wait_i(conv_wait),
    .conv_dout_o(conv_dout), .conv_wr_o(conv_wr),
    .dac_sel_o(dac_sel), .adc_sel_o(adc_sel),
    .adc_start_o(adc_start), .adc_rd_o(adc_rd), .adc_din_i(adc_din)
  );

  // strobe vector: {write, dac select, adc select, start, read}
  function automatic logic [4:0] strobes();
    return {conv_wr, dac_sel, adc_sel, adc_start, adc_rd};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic host_write(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    step();
    io_wr = 1'b0;
  endtask

  task automatic host_read(input logic [15:0] a, output logic [15:0] d);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    step();
    io_rd = 1'b0;
  endtask

  task automatic wait_dac(input string req);
    bit found = 0;
    for (int i = 0; i < 500 && !found; i++) begin
      step();
      if (conv_wr && dac_sel) found = 1;
    end
    chk(req, found, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; io_addr = 16'h0002; io_rd = 1'b1; io_wr = 1'b0; io_wdata = '0;
    tick_reload = 16'd40; conv_wait = 8'd5; adc_din = '0;
    repeat (3) step();
    chk("R1 reset strobes", strobes(), 5'b0);
    chk("R7 reset read", io_rdata, 16'h0000);
    io_rd = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_init();
    bit found = 0;
    bit early = 0;
    for (int i = 0; i < 10 && !found; i++) begin
      step();
      if (conv_wr) found = 1;
      else if (strobes() != 5'b0) early = 1;
    end
    chk("R1 setup write seen", found, 1);
    chk("R1 nothing before setup", early, 0);
    chk("R1 first setup strobes", strobes(), 5'b10100);
    chk("R1 first setup word", conv_dout, 16'h00C0);
    step();
    chk("R1 second setup strobes", strobes(), 5'b10100);
    chk("R1 second setup word", conv_dout, 16'h0100);
    step();
    chk("R1 quiet after setup", strobes(), 5'b0);
  endtask

  task automatic t_stage();
    logic [15:0] d;
    host_write(16'h0001, 8'hA5);
    host_read(16'h0001, d);  chk("R9 staged readback", d, 16'h00A5);
    host_write(16'h0003, 8'h3C);
    host_write(16'h0101, 8'h3C);
    host_read(16'h0001, d);  chk("R10 stray writes ignored", d, 16'h00A5);
    host_read(16'h0003, d);  chk("R10 unmapped read 0x0003", d, 16'h0000);
    host_read(16'h8001, d);  chk("R10 unmapped read 0x8001", d, 16'h0000);
  endtask

  task automatic t_sequence();
    logic [15:0] d;
    adc_din = 10'h2B7;
    wait_dac("R4 dac write");
    chk("R4 dac strobes", strobes(), 5'b11000);
    chk("R4 dac data", conv_dout, 16'h00A5);
    step();
    chk("R4 start strobes", strobes(), 5'b00110);
    io_addr = 16'h0002; io_rd = 1'b1;     // drop stale flags during start
    step();
    io_rd = 1'b0;
    chk("R5 wait cycle 1", strobes(), 5'b0);
    for (int k = 2; k <= 5; k++) begin
      step();
      chk("R5 wait cycle", strobes(), 5'b0);
    end
    step();
    chk("R5 read strobes", strobes(), 5'b00101);
    step();
    chk("R5 quiet after read", strobes(), 5'b0);
    host_read(16'h0002, d);  chk("R6 captured sample", d, 16'h82B7);
    host_read(16'h0002, d);  chk("R7 valid cleared", d, 16'h02B7);
  endtask

  task automatic t_zero_wait();
    conv_wait = 8'd0;
    wait_dac("R5 dac write");
    step();
    chk("R5 zero-wait start", strobes(), 5'b00110);
    step();
    chk("R5 zero-wait read", strobes(), 5'b00101);
    step();
    chk("R5 zero-wait idle", strobes(), 5'b0);
  endtask

  task automatic t_period();
    int c1;
    wait_dac("R3 first");
    c1 = cyc;
    wait_dac("R3 second");
    chk("R3 period reload 40", cyc - c1, 41);
    tick_reload = 16'd19;
    wait_dac("R3 transition");
    c1 = cyc;
    wait_dac("R3 after change");
    chk("R3 period reload 19", cyc - c1, 20);
  endtask

  task automatic t_overrun();
    logic [15:0] d;
    adc_din = 10'h155;
    wait_dac("R8 dac write");
    step();
    io_addr = 16'h0002; io_rd = 1'b1;
    step();
    io_rd = 1'b0;
    step();
    adc_din = 10'h0AA;
    wait_dac("R8 second dac write");
    step(); step(); step();
    host_read(16'h0003, d);  chk("R10 unmapped read keeps flags", d, 16'h0000);
    host_read(16'h0000, d);  chk("R10 unmapped read 0x0000", d, 16'h0000);
    host_read(16'h0002, d);  chk("R8 overrun flagged", d, 16'hC0AA);
    host_read(16'h0002, d);  chk("R8 overrun cleared by read", d, 16'h00AA);
  endtask

  initial begin
    t_reset();
    t_init();
    t_stage();
    t_sequence();
    t_zero_wait();
    t_period();
    t_overrun();
    chk("R2 select clash count", sel_clash, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule